// File: doc/BRIEF.md
# Write Protection Unlock Sequencer

This block sits between the write decoder and the write path of a byte-wide nonvolatile memory. Every decoded write reaches it as an address, a data byte and a one-cycle valid pulse. For each write it makes one of three decisions. The write can pass to the array, it can be swallowed as a command byte, or it can be dropped. It also holds a protection flag that stands for a nonvolatile bit. While that flag is clear, ordinary writes pass freely.

A three-write unlock prefix sets the protection flag and opens a single page-load window. The prefix is data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Up to PAGE_BYTES writes may pass during the window. The window closes when the neighbouring page controller pulses `page_done`, and protected writes are blocked again. A six-write disable command clears the flag, but only after the programming delay that the same controller signals. That command is 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, then 0x20 to 0x5555. The block does not buffer pages and does not time programming.

All outputs are registered. The result of a write captured at clock edge N appears on the outputs after edge N.

Top module: `wp_unlock_seq`

## Requirements
- R1: After synchronous reset, `prot_on`, `arr_wr` and `cmd_swallow` are 0.
- R2: While `prot_on` is 0 and no sequence step matches, a write produces one `arr_wr` pulse in the next cycle. That pulse carries the same `arr_addr` and `arr_data`.
- R3: Each byte of the unlock prefix (0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555) pulses `cmd_swallow` and does not pulse `arr_wr`. After the third byte, `prot_on` is 1.
- R4: After the prefix, the first PAGE_BYTES writes (default 128) pass to the array. Any further writes in the same window are dropped, with no `arr_wr` and no `cmd_swallow`.
- R5: A `page_done` pulse closes an open window. While `prot_on` is 1, later plain writes are dropped.
- R6: While `prot_on` is 1 and no window is open, a write that matches no sequence step produces neither `arr_wr` nor `cmd_swallow`.
- R7: A write that does not match the next expected step resets the partial sequence. That write passes if `prot_on` is 0 and is dropped if it is 1. The next write is then matched against the first step.
- R8: Each byte of the disable command pulses `cmd_swallow`. After the sixth byte, writes are dropped and `prot_on` stays 1 until `page_done`. After `page_done`, `prot_on` is 0 and plain writes pass again.
- R9: Address bit 15 is ignored when a write is matched against the command addresses.
- R10: The unlock prefix opens a window whether `prot_on` was 0 or 1 beforehand.
- R11: A `page_done` pulse while no window is open and no disable is pending changes neither `prot_on` nor the sequence progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (first use) |
| wr_valid | input | 1 | One-cycle pulse marking a decoded write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| page_done | input | 1 | Page cycle or programming delay finished, from the page controller |
| arr_wr | output | 1 | Registered strobe that forwards the write to the array |
| arr_addr | output | ADDR_W | Address forwarded with `arr_wr` |
| arr_data | output | DATA_W | Data forwarded with `arr_wr` |
| cmd_swallow | output | 1 | Registered pulse: the write was taken as a command byte |
| prot_on | output | 1 | Current protection state |

## Verification
The bench loads PAGE_BYTES + 2 bytes into one window. A design with an off-by-one page limit would forward the 129th byte or drop the 128th. It breaks off sequences at the second and third steps, and then sends the remaining steps on their own. A design that kept its partial progress after a mismatch would unlock without a full prefix. It sets bit 15 of the command addresses, pulses `page_done` outside a window, and writes while a disable is pending. Those cases catch a full-width address compare, a flag that clears too early, and a window that reopens by itself.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_D3,
    ST_D4,
    ST_D5,
    ST_OPEN,
    ST_DWAIT
  } seq_st_t;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_AA_KA,
    TK_55_KB,
    TK_A0_KA,
    TK_80_KA,
    TK_20_KA
  } tok_t;

endpackage

// File: rtl/wps_token_decode.sv
module wps_token_decode
  import wp_seq_pkg::*;
#(
  parameter int MATCH_W = 15,
  parameter int DATA_W  = 8,
  parameter logic [MATCH_W-1:0] KEY_A = 15'h5555,
  parameter logic [MATCH_W-1:0] KEY_B = 15'h2AAA,
  parameter logic [DATA_W-1:0]  D_OPEN1 = 8'hAA,
  parameter logic [DATA_W-1:0]  D_OPEN2 = 8'h55,
  parameter logic [DATA_W-1:0]  D_UNLK  = 8'hA0,
  parameter logic [DATA_W-1:0]  D_DIS1  = 8'h80,
  parameter logic [DATA_W-1:0]  D_DIS2  = 8'h20
) (
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [DATA_W-1:0]  data,
  output tok_t               tok
);

  logic hit_a, hit_b;

  assign hit_a = (addr_lo == KEY_A);
  assign hit_b = (addr_lo == KEY_B);

  always_comb begin
    tok = TK_NONE;
    if (hit_a) begin
      if (data == D_OPEN1)      tok = TK_AA_KA;
      else if (data == D_UNLK)  tok = TK_A0_KA;
      else if (data == D_DIS1)  tok = TK_80_KA;
      else if (data == D_DIS2)  tok = TK_20_KA;
    end else if (hit_b && data == D_OPEN2) begin
      tok = TK_55_KB;
    end
  end

endmodule

// File: rtl/wps_window_count.sv
module wps_window_count #(
  parameter int PAGE_BYTES = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic room
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (bump)    cnt <= cnt + 1'b1;
  end

  assign room = (cnt < LIMIT);

  assert_cap_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  assert_bump_room_R4: assert property (@(posedge clk) disable iff (rst)
    (bump && !clear) |=> (cnt != '0));

endmodule

// File: rtl/wps_seq_fsm.sv
module wps_seq_fsm
  import wp_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  tok_t tok,
  input  logic page_done,
  input  logic room,
  output logic act_pass,
  output logic act_swallow,
  output logic win_clear,
  output logic win_bump,
  output logic prot_q
);

  seq_st_t st, nxt;
  logic    step_ok;
  seq_st_t step_nxt;
  logic    set_p, clr_p;

  // progress along the command sequences
  always_comb begin
    step_ok  = 1'b0;
    step_nxt = ST_IDLE;
    case (st)
      ST_IDLE: if (tok == TK_AA_KA) begin step_ok = 1'b1; step_nxt = ST_U1; end
      ST_U1:   if (tok == TK_55_KB) begin step_ok = 1'b1; step_nxt = ST_U2; end
      ST_U2: begin
        if (tok == TK_A0_KA)      begin step_ok = 1'b1; step_nxt = ST_OPEN; end
        else if (tok == TK_80_KA) begin step_ok = 1'b1; step_nxt = ST_D3; end
      end
      ST_D3:   if (tok == TK_AA_KA) begin step_ok = 1'b1; step_nxt = ST_D4; end
      ST_D4:   if (tok == TK_55_KB) begin step_ok = 1'b1; step_nxt = ST_D5; end
      ST_D5:   if (tok == TK_20_KA) begin step_ok = 1'b1; step_nxt = ST_DWAIT; end
      default: ;
    endcase
  end

  always_comb begin
    nxt         = st;
    act_pass    = 1'b0;
    act_swallow = 1'b0;
    win_clear   = 1'b0;
    win_bump    = 1'b0;
    set_p       = 1'b0;
    clr_p       = 1'b0;
    if (wr_valid) begin
      if (st == ST_OPEN) begin
        if (room) begin
          act_pass = 1'b1;
          win_bump = 1'b1;
        end
      end else if (st != ST_DWAIT) begin
        if (step_ok) begin
          act_swallow = 1'b1;
          nxt         = step_nxt;
          if (step_nxt == ST_OPEN) begin
            set_p     = 1'b1;
            win_clear = 1'b1;
          end
        end else begin
          nxt      = ST_IDLE;
          act_pass = !prot_q;
        end
      end
    end
    if (page_done) begin
      if (st == ST_OPEN) begin
        nxt = ST_IDLE;
      end else if (st == ST_DWAIT) begin
        nxt   = ST_IDLE;
        clr_p = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      prot_q <= 1'b0;
    end else begin
      st <= nxt;
      if (set_p)      prot_q <= 1'b1;
      else if (clr_p) prot_q <= 1'b0;
    end
  end

  assert_prefix_locks_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && st == ST_U2 && tok == TK_A0_KA) |=> (prot_q && st == ST_OPEN));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (prot_q && !(st == ST_DWAIT && page_done)) |=> prot_q);

  assert_wait_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DWAIT) |-> !(act_pass || act_swallow));

  assert_idle_done_R11: assert property (@(posedge clk) disable iff (rst)
    (page_done && !wr_valid && st != ST_OPEN && st != ST_DWAIT) |=> $stable(st));

endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              page_done,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              cmd_swallow,
  output logic              prot_on
);

  localparam int MATCH_W = ADDR_W - 1;

  tok_t tok;
  logic act_pass, act_swallow, win_clear, win_bump, room, prot_q;

  wps_token_decode #(
    .MATCH_W (MATCH_W),
    .DATA_W  (DATA_W),
    .KEY_A   (MATCH_W'(15'h5555)),
    .KEY_B   (MATCH_W'(15'h2AAA))
  ) i_dec (
    .addr_lo (wr_addr[MATCH_W-1:0]),
    .data    (wr_data),
    .tok     (tok)
  );

  wps_seq_fsm i_fsm (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .tok         (tok),
    .page_done   (page_done),
    .room        (room),
    .act_pass    (act_pass),
    .act_swallow (act_swallow),
    .win_clear   (win_clear),
    .win_bump    (win_bump),
    .prot_q      (prot_q)
  );

  wps_window_count #(.PAGE_BYTES(PAGE_BYTES)) i_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (win_clear),
    .bump  (win_bump),
    .room  (room)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_wr      <= 1'b0;
      cmd_swallow <= 1'b0;
      arr_addr    <= '0;
      arr_data    <= '0;
    end else begin
      arr_wr      <= act_pass;
      cmd_swallow <= act_swallow;
      if (act_pass) begin
        arr_addr <= wr_addr;
        arr_data <= wr_data;
      end
    end
  end

  assign prot_on = prot_q;

  assert_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(arr_wr && cmd_swallow));

  assert_strobe_src_R2: assert property (@(posedge clk) disable iff (rst)
    arr_wr |-> $past(wr_valid));

  assert_swallow_src_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_swallow |-> $past(wr_valid));

  assert_addr_fwd_R2: assert property (@(posedge clk) disable iff (rst)
    arr_wr |-> (arr_addr == $past(wr_addr) && arr_data == $past(wr_data)));

endmodule

// File: tb/test_wp_unlock_seq.sv
module test_wp_unlock_seq;

  localparam int PB = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wv = 1'b0;
  logic [15:0] wa = '0;
  logic [7:0]  wd = '0;
  logic        pd = 1'b0;
  logic        arr_wr, cmd_swallow, prot_on;
  logic [15:0] arr_addr;
  logic [7:0]  arr_data;

  always #2.5 clk = ~clk;

  wp_unlock_seq i_wp_unlock_seq (
    .clk(clk), .rst(rst), .wr_valid(wv), .wr_addr(wa), .wr_data(wd),
    .page_done(pd), .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_data(arr_data),
    .cmd_swallow(cmd_swallow), .prot_on(prot_on)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  // behavioural reference: position along the disable list, mode 0 idle, 1 window, 2 wait
  logic [14:0] seq_a [6] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555};
  logic [7:0]  seq_d [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
  int          pos = 0, mode = 0, cnt = 0;
  bit          m_prot = 0, e_wr = 0, e_sw = 0;
  logic [15:0] e_addr = '0;
  logic [7:0]  e_data = '0;

  always @(posedge clk) begin
    e_wr = 0; e_sw = 0;
    if (rst) begin
      pos = 0; mode = 0; cnt = 0; m_prot = 0;
    end else begin
      if (wv) begin
        if (mode == 1) begin
          if (cnt < PB) begin e_wr = 1; cnt++; e_addr = wa; e_data = wd; end
        end else if (mode == 2) begin
        end else if (pos == 2 && wa[14:0] == 15'h5555 && wd == 8'hA0) begin
          e_sw = 1; mode = 1; cnt = 0; m_prot = 1; pos = 0;
        end else if (wa[14:0] == seq_a[pos] && wd == seq_d[pos]) begin
          e_sw = 1; pos++;
          if (pos == 6) begin mode = 2; pos = 0; end
        end else begin
          pos = 0;
          if (!m_prot) begin e_wr = 1; e_addr = wa; e_data = wd; end
        end
      end
      if (pd) begin
        if (mode == 1) mode = 0;
        else if (mode == 2) begin mode = 0; m_prot = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (arr_wr !== e_wr || cmd_swallow !== e_sw || prot_on !== m_prot ||
          (e_wr && (arr_addr !== e_addr || arr_data !== e_data))) begin
        fails++;
        $display("FAIL %s: wr/sw/prot/addr/data actual %b %b %b %h %h expected %b %b %b %h %h",
                 cur_req, arr_wr, cmd_swallow, prot_on, arr_addr, arr_data,
                 e_wr, e_sw, m_prot, e_addr, e_data);
      end
    end
  end

  task automatic chk(input string req, input bit w, input bit s, input bit p);
    checks++;
    if (arr_wr !== w || cmd_swallow !== s || prot_on !== p) begin
      fails++;
      $display("FAIL %s: wr/sw/prot actual %b %b %b expected %b %b %b",
               req, arr_wr, cmd_swallow, prot_on, w, s, p);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1; wv = 1; wa = a; wd = d;
    @(negedge clk); #1; wv = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); #1; pd = 1;
    @(negedge clk); #1; pd = 0;
  endtask

  task automatic unlock(input logic [15:0] hi);
    wr(hi | 16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(hi | 16'h5555, 8'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    chk("R1", 0, 0, 0);

    cur_req = "R2";
    wr(16'h1234, 8'h5A); chk("R2", 1, 0, 0);
    wr(16'h8001, 8'hFF); chk("R2", 1, 0, 0);
    wr(16'h5555, 8'h00); chk("R2", 1, 0, 0);

    cur_req = "R9";
    wr(16'hD555, 8'hAA); chk("R9", 0, 1, 0);
    cur_req = "R7";
    wr(16'h0100, 8'h11); chk("R7", 1, 0, 0);

    cur_req = "R3";
    wr(16'h5555, 8'hAA); chk("R3", 0, 1, 0);
    wr(16'hAAAA, 8'h55); chk("R3", 0, 1, 0);
    wr(16'hD555, 8'hA0); chk("R3", 0, 1, 1);

    cur_req = "R4";
    for (int i = 0; i < PB + 2; i++) begin
      wr(16'h0400 + 16'(i), 8'(i));
      if (i == PB - 1) chk("R4", 1, 0, 1);
      if (i == PB)     chk("R4", 0, 0, 1);
    end
    cur_req = "R5";
    done_pulse();
    wr(16'h0400, 8'h77); chk("R5", 0, 0, 1);

    cur_req = "R6";
    wr(16'h2AAA, 8'h55); chk("R6", 0, 0, 1);
    wr(16'h0042, 8'h42); chk("R6", 0, 0, 1);

    cur_req = "R7";
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h00); chk("R7", 0, 0, 1);
    wr(16'h5555, 8'hA0); chk("R7", 0, 0, 1);
    wr(16'h0010, 8'h10); chk("R7", 0, 0, 1);
    wr(16'h5555, 8'hAA);
    wr(16'h1234, 8'h55); chk("R7", 0, 0, 1);
    wr(16'h2AAA, 8'h55); chk("R7", 0, 0, 1);

    cur_req = "R11";
    wr(16'h5555, 8'hAA);
    done_pulse();
    wr(16'h2AAA, 8'h55); chk("R11", 0, 1, 1);
    wr(16'h5555, 8'hA0); chk("R11", 0, 1, 1);
    wr(16'h0800, 8'h01); chk("R11", 1, 0, 1);
    done_pulse();
    done_pulse();
    wr(16'h0800, 8'h02); chk("R11", 0, 0, 1);

    cur_req = "R10";
    unlock(16'h0000);
    wr(16'h0900, 8'h09); chk("R10", 1, 0, 1);
    wr(16'h0901, 8'h0A); chk("R10", 1, 0, 1);
    done_pulse();

    cur_req = "R8";
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55);
    wr(16'h5555, 8'h20); chk("R8", 0, 1, 1);
    wr(16'h0123, 8'h45); chk("R8", 0, 0, 1);
    wr(16'h5555, 8'hAA); chk("R8", 0, 0, 1);
    done_pulse();
    chk("R8", 0, 0, 0);
    wr(16'h0123, 8'h46); chk("R8", 1, 0, 0);

    cur_req = "R10";
    unlock(16'h8000);
    chk("R10", 0, 1, 1);
    wr(16'h0A00, 8'hAB); chk("R10", 1, 0, 1);
    done_pulse();
    wr(16'h0A01, 8'hAC); chk("R10", 0, 0, 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule